// File: doc/BRIEF.md
# Nibble Stream Demultiplexer with Embedded Sync Recovery

This block sits at the entry of a camera video pipeline. A camera sends its sensor samples four bits at a time, each nibble marked by a rising edge on that port's own pixel clock line. There are two such camera ports. The block samples both pixel clocks into the core clock domain, follows only the port chosen by a configuration input, and rebuilds 8-bit samples from pairs of nibbles, high nibble first.

Line and frame timing travel inside the data stream as escape sequences, not on wires. The escape byte is 0xFF. It is followed by a code byte: 0x01 opens an active line, 0x02 closes it, 0x03 starts a frame, and 0x00 stands for a literal 0xFF sample. The block strips the escapes and produces one sample strobe per recovered pixel, a line-active qualifier, a one-cycle horizontal sync pulse at each line end and a one-cycle vertical sync pulse at each frame start. The marker search looks at the raw nibble sequence and ignores byte phase, so a lost nibble is repaired at the next marker.

Top module: `cam_nibble_demux`

## Requirements
- R1: Out of reset, pix_valid, line_active, hsync and vsync are low and cur_port is 0.
- R2: Each recovered sample on pix_data is built from two nibbles taken on rising edges of the selected port's pixel clock, the first nibble forming bits 7:4 and the second bits 3:0.
- R3: The byte pair 0xFF 0x01 sets line_active. pix_valid is raised only while line_active is set.
- R4: The byte pair 0xFF 0x02 clears line_active and raises hsync for exactly one clock cycle.
- R5: The byte pair 0xFF 0x03 clears line_active and raises vsync for exactly one clock cycle. Samples that follow it are not output until the next 0xFF 0x01.
- R6: The byte pair 0xFF 0x00 yields exactly one output sample of value 0xFF.
- R7: Escape and code bytes never appear as output samples. A line of N pixel samples yields exactly N pix_valid pulses.
- R8: A new value on cfg_port_sel takes effect only when a 0xFF 0x03 arrives on the current port. cur_port then shows the new port. Traffic on the port that is not selected has no effect on any output.
- R9: A marker is recognised when the nibble run 0xF, 0xF, 0x0, code (code 1 to 3) is seen at any nibble phase. After the marker, pairing restarts on a high nibble, so a dropped nibble is repaired by the next marker.
- R10: 0xFF followed by any byte other than 0x00 to 0x03 is dropped, together with that byte.
- R11: Samples that arrive while no line is open produce no pix_valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; the pixel clocks are sampled in this domain |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_port_sel | input | 1 | Requested camera port, applied at the next frame start |
| cam_pclk | input | 2 | Pixel clock of each camera port, one bit per port |
| cam_nib | input | 8 | Nibble data of each port; port p occupies bits 4p+3:4p |
| pix_data | output | 8 | Recovered sample |
| pix_valid | output | 1 | One-cycle strobe qualifying pix_data |
| line_active | output | 1 | High between line-start and line-end markers |
| hsync | output | 1 | One-cycle pulse at each line-end marker |
| vsync | output | 1 | One-cycle pulse at each frame-start marker |
| cur_port | output | 1 | Port currently feeding the pipeline |

## Verification
The bench pushes lines that contain literal 0xFF values, including two back to back. A decoder that mishandles the escape would drop those pixels, let a 0x00 through, or misread the second 0xFF as a new escape. One line is misaligned on purpose by a single nibble before its line-end marker. A decoder that searches only on byte boundaries would then keep the line open and lose the next line. The bench also sends traffic on the port that is not selected and changes the port request in the middle of a frame. A design that switches ports at once, or that listens to both ports, would produce pixels from the wrong camera. The remaining tests cover a malformed escape and samples sent before any line start. Both must leave pix_valid low.

// File: rtl/cam_demux_pkg.sv
// Shared types for the nibble stream demultiplexer.
// The code values of mark_e are the low bits of the code byte that follows an escape.
package cam_demux_pkg;
    typedef enum logic [1:0] {
        MK_NONE = 2'd0,
        MK_SAV  = 2'd1,
        MK_EAV  = 2'd2,
        MK_SOF  = 2'd3
    } mark_e;
endpackage

// File: rtl/cam_port_sampler.sv
// Samples one camera port into the core clock domain.
// Assumes the pixel clock stays high and low for at least one core clock each,
// and that the nibble is stable around its rising edge. The data pipeline has the
// same length as the clock synchroniser, so each nibble lines up with its edge.
module cam_port_sampler #(
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pclk,
    input  logic [NIB_W-1:0] nib_in,
    output logic             nib_stb,
    output logic [NIB_W-1:0] nib_out
);
    logic [SYNC_STAGES:0] clk_pipe;
    logic [NIB_W-1:0]     dat_pipe [SYNC_STAGES];

    // Shift the pixel clock through the synchroniser plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_pipe <= '0;
        else        clk_pipe <= {clk_pipe[SYNC_STAGES-1:0], pclk};
    end

    // First data stage captures the nibble lines.
    always_ff @(posedge clk) begin
        if (!rst_n) dat_pipe[0] <= '0;
        else        dat_pipe[0] <= nib_in;
    end

    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_dat
            // Delay the data in step with the clock synchroniser.
            always_ff @(posedge clk) begin
                if (!rst_n) dat_pipe[s] <= '0;
                else        dat_pipe[s] <= dat_pipe[s-1];
            end
        end
    endgenerate

    assign nib_stb = clk_pipe[SYNC_STAGES-1] & ~clk_pipe[SYNC_STAGES];
    assign nib_out = dat_pipe[SYNC_STAGES-1];
endmodule

// File: rtl/cam_marker_scan.sv
// Looks for the nibble run F,F,0,c (c = 1..3) at any nibble phase.
// Assumes the caller feeds it only the selected port's nibbles. The history is
// cleared after each hit, so the nibbles of one marker cannot form a second one.
module cam_marker_scan
    import cam_demux_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_stb,
    input  logic [NIB_W-1:0] nib,
    output mark_e            mark
);
    localparam logic [NIB_W-1:0] ALL1 = '1;
    localparam logic [NIB_W-1:0] ZERO = '0;

    logic [NIB_W-1:0] h0, h1, h2;   // h0 is the most recent nibble
    logic             code_ok;

    // Decide whether the current nibble closes a marker.
    always_comb begin
        code_ok = (nib != ZERO) && (nib < NIB_W'(4));
        mark    = MK_NONE;
        if (nib_stb && h2 == ALL1 && h1 == ALL1 && h0 == ZERO && code_ok)
            mark = mark_e'(nib[1:0]);
    end

    // Keep the last three nibbles; clear them after a marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h0 <= '0; h1 <= '0; h2 <= '0;
        end else if (nib_stb) begin
            if (mark != MK_NONE) begin
                h0 <= '0; h1 <= '0; h2 <= '0;
            end else begin
                h2 <= h1; h1 <= h0; h0 <= nib;
            end
        end
    end
endmodule

// File: rtl/cam_nibble_pair.sv
// Pairs nibbles into bytes, high nibble first, and removes the 0xFF escape.
// Assumes restart is raised on the code nibble of every marker. Pairing then
// begins again on a high nibble, and any held escape is discarded.
module cam_nibble_pair #(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nib_stb,
    input  logic [NIB_W-1:0]  nib,
    input  logic              restart,
    output logic              smp_stb,
    output logic [BYTE_W-1:0] smp_val
);
    localparam logic [BYTE_W-1:0] ESC = '1;

    logic             half;   // a high nibble is held
    logic             pend;   // an escape byte is held
    logic [NIB_W-1:0] hi;
    logic [BYTE_W-1:0] cur_byte;

    assign cur_byte = {hi, nib};

    // Produce a sample when a byte completes and is not part of an escape.
    always_comb begin
        smp_stb = 1'b0;
        smp_val = cur_byte;
        if (nib_stb && !restart && half) begin
            if (pend) begin
                smp_stb = (cur_byte == '0);
                smp_val = ESC;
            end else begin
                smp_stb = (cur_byte != ESC);
            end
        end
    end

    // Track the nibble phase and the escape state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half <= 1'b0;
            pend <= 1'b0;
            hi   <= '0;
        end else if (nib_stb) begin
            if (restart) begin
                half <= 1'b0;
                pend <= 1'b0;
            end else if (!half) begin
                hi   <= nib;
                half <= 1'b1;
            end else begin
                half <= 1'b0;
                pend <= !pend && (cur_byte == ESC);
            end
        end
    end
endmodule

// File: rtl/cam_nibble_demux.sv
// Top level: samples every camera port, follows the selected one, recovers
// samples and line and frame timing from the escape codes in the stream.
// Assumes cfg_port_sel is static long enough to be seen at a frame start.
// The port switch happens only on a frame-start marker of the current port.
module cam_nibble_demux
    import cam_demux_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int NUM_PORTS   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SEL_W-1:0]           cfg_port_sel,
    input  logic [NUM_PORTS-1:0]       cam_pclk,
    input  logic [NUM_PORTS*NIB_W-1:0] cam_nib,
    output logic [2*NIB_W-1:0]         pix_data,
    output logic                       pix_valid,
    output logic                       line_active,
    output logic                       hsync,
    output logic                       vsync,
    output logic [SEL_W-1:0]           cur_port
);
    localparam int BYTE_W = 2 * NIB_W;

    logic [NUM_PORTS-1:0] port_stb;
    logic [NIB_W-1:0]     port_nib [NUM_PORTS];
    logic                 sel_stb;
    logic [NIB_W-1:0]     sel_nib;
    mark_e                mark;
    logic                 smp_stb;
    logic [BYTE_W-1:0]    smp_val;
    logic                 sel_ok;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            cam_port_sampler #(
                .NIB_W      (NIB_W),
                .SYNC_STAGES(SYNC_STAGES)
            ) u_smp (
                .clk    (clk),
                .rst_n  (rst_n),
                .pclk   (cam_pclk[p]),
                .nib_in (cam_nib[p*NIB_W +: NIB_W]),
                .nib_stb(port_stb[p]),
                .nib_out(port_nib[p])
            );
        end
    endgenerate

    // Route the current port's nibble events into the decoder.
    always_comb begin
        sel_stb = port_stb[cur_port];
        sel_nib = port_nib[cur_port];
    end

    cam_marker_scan #(.NIB_W(NIB_W)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .nib_stb(sel_stb),
        .nib    (sel_nib),
        .mark   (mark)
    );

    cam_nibble_pair #(.NIB_W(NIB_W)) u_pair (
        .clk    (clk),
        .rst_n  (rst_n),
        .nib_stb(sel_stb),
        .nib    (sel_nib),
        .restart(mark != MK_NONE),
        .smp_stb(smp_stb),
        .smp_val(smp_val)
    );

    assign sel_ok = int'(cfg_port_sel) < NUM_PORTS;

    // Register the samples and their strobe; only samples inside a line are valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_data  <= '0;
        end else begin
            pix_valid <= smp_stb && line_active;
            if (smp_stb) pix_data <= smp_val;
        end
    end

    // Line and frame state, the sync pulses and the port switch at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_active <= 1'b0;
            hsync       <= 1'b0;
            vsync       <= 1'b0;
            cur_port    <= '0;
        end else begin
            hsync <= (mark == MK_EAV);
            vsync <= (mark == MK_SOF);
            case (mark)
                MK_SAV: line_active <= 1'b1;
                MK_EAV: line_active <= 1'b0;
                MK_SOF: begin
                    line_active <= 1'b0;
                    if (sel_ok) cur_port <= cfg_port_sel;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cam_demux_chk.sv
// Checker for cam_nibble_demux, bound to every instance of the top module.
// Assumes rst_n is low for at least one clock at start-up.
module cam_demux_chk #(
    parameter int SEL_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic             line_active,
    input logic             hsync,
    input logic             vsync,
    input logic [SEL_W-1:0] cur_port
);
    // R3: a sample is valid only inside an open line.
    assert_valid_in_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> line_active);

    // R4: a line end leaves the line closed.
    assert_hsync_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> !line_active);

    // R4: the hsync pulse lasts one cycle.
    assert_hsync_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> !hsync);

    // R5: a frame start leaves the line closed, and vsync lasts one cycle.
    assert_vsync_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> !line_active);
    assert_vsync_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> !vsync);

    // R7: one event per nibble; a marker never comes with a sample.
    assert_one_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pix_valid, hsync, vsync}));

    // R3: the cycle that opens a line carries no sample.
    assert_open_no_pixel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_active) |-> !pix_valid);

    // R8: the port changes only together with a frame start.
    assert_port_at_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_port) |-> vsync);
endmodule

bind cam_nibble_demux cam_demux_chk #(.SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .line_active(line_active),
    .hsync      (hsync),
    .vsync      (vsync),
    .cur_port   (cur_port)
);

// File: tb/sim_cam_nibble_demux.sv
module sim_cam_nibble_demux;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_port_sel = 1'b0;
    logic [1:0] cam_pclk = 2'b00;
    logic [7:0] cam_nib = 8'h00;
    logic [7:0] pix_data;
    logic       pix_valid, line_active, hsync, vsync;
    logic       cur_port;

    int total = 0;
    int bad = 0;
    int ng = 0;
    int nh = 0;
    int nv = 0;
    int cyc = 0;
    logic [7:0] got [512];

    always #2.5 clk = ~clk;

    cam_nibble_demux u0 (
        .clk(clk), .rst_n(rst_n), .cfg_port_sel(cfg_port_sel),
        .cam_pclk(cam_pclk), .cam_nib(cam_nib),
        .pix_data(pix_data), .pix_valid(pix_valid), .line_active(line_active),
        .hsync(hsync), .vsync(vsync), .cur_port(cur_port)
    );

    // Record the output events away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pix_valid) begin
                if (ng < 512) got[ng] = pix_data;
                ng = ng + 1;
            end
            if (hsync) nh = nh + 1;
            if (vsync) nv = nv + 1;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_nib(input int p, input logic [3:0] n);
        @(negedge clk);
        cam_nib[p*4 +: 4] = n;
        idle(1);
        cam_pclk[p] = 1'b1;
        idle(3);
        cam_pclk[p] = 1'b0;
        idle(2);
    endtask

    task automatic send_raw(input int p, input logic [7:0] b);
        send_nib(p, b[7:4]);
        send_nib(p, b[3:0]);
    endtask

    task automatic send_pix(input int p, input logic [7:0] b);
        send_raw(p, b);
        if (b == 8'hFF) send_raw(p, 8'h00);
    endtask

    task automatic send_mark(input int p, input logic [7:0] code);
        send_raw(p, 8'hFF);
        send_raw(p, code);
    endtask

    localparam logic [31:0] VEC [8] = '{
        32'h01234567, 32'hFF00FF10, 32'h80FE7F0F, 32'hA5C33CEE,
        32'h00000000, 32'h11FFFF22, 32'hDEADBEEF, 32'h7E810102
    };

    initial begin
        int base;
        int hb;
        int vb;
        idle(4);
        // R1: reset state
        chk(pix_valid == 0 && hsync == 0 && vsync == 0, "R1 strobes", {pix_valid, hsync, vsync}, 0);
        chk(line_active == 0, "R1 line_active", line_active, 0);
        chk(cur_port == 0, "R1 cur_port", cur_port, 0);
        rst_n = 1'b1;
        idle(4);

        // R11: samples before any line start are not output
        base = ng;
        send_pix(0, 8'h55);
        send_pix(0, 8'h66);
        idle(4);
        chk(ng == base, "R11 no pixel outside line", ng - base, 0);

        // Vector table: one line per entry (R2, R3, R4, R6, R7)
        for (int v = 0; v < 8; v++) begin
            base = ng;
            hb = nh;
            send_mark(0, 8'h01);
            for (int k = 3; k >= 0; k--) send_pix(0, VEC[v][k*8 +: 8]);
            chk(line_active == 1, "R3 line open", line_active, 1);
            send_mark(0, 8'h02);
            idle(4);
            chk(ng - base == 4, "R7 sample count", ng - base, 4);
            for (int j = 0; j < 4; j++)
                chk(got[base+j] == VEC[v][(3-j)*8 +: 8], "R2/R6 sample value",
                    got[base+j], VEC[v][(3-j)*8 +: 8]);
            chk(line_active == 0, "R4 line closed", line_active, 0);
            chk(nh - hb == 1, "R4 one hsync", nh - hb, 1);
        end

        // R5: frame start inside a line closes it; later samples are dropped
        base = ng;
        vb = nv;
        send_mark(0, 8'h01);
        send_pix(0, 8'h11);
        send_mark(0, 8'h03);
        send_pix(0, 8'h22);
        idle(4);
        chk(nv - vb == 1, "R5 one vsync", nv - vb, 1);
        chk(line_active == 0, "R5 line closed", line_active, 0);
        chk(ng - base == 1 && got[base] == 8'h11, "R5 samples", ng - base, 1);

        // R10: malformed escape is dropped with its code byte
        base = ng;
        send_mark(0, 8'h01);
        send_raw(0, 8'hFF);
        send_raw(0, 8'h05);
        send_pix(0, 8'h33);
        send_mark(0, 8'h02);
        idle(4);
        chk(ng - base == 1, "R10 count", ng - base, 1);
        chk(got[base] == 8'h33, "R10 value", got[base], 8'h33);

        // R9: one stray nibble misaligns the stream; the marker still closes the line
        hb = nh;
        send_mark(0, 8'h01);
        send_pix(0, 8'h12);
        send_nib(0, 4'hA);
        send_mark(0, 8'h02);
        idle(4);
        chk(line_active == 0, "R9 misaligned end seen", line_active, 0);
        chk(nh - hb == 1, "R9 hsync on misaligned end", nh - hb, 1);
        base = ng;
        send_mark(0, 8'h01);
        send_pix(0, 8'h44);
        send_mark(0, 8'h02);
        idle(4);
        chk(ng - base == 1 && got[base] == 8'h44, "R9 realigned line", got[base], 8'h44);

        // R8: a port request waits for a frame start; the other port is ignored
        cfg_port_sel = 1'b1;
        base = ng;
        send_mark(1, 8'h01);
        send_pix(1, 8'h77);
        send_mark(1, 8'h02);
        idle(4);
        chk(ng == base && line_active == 0, "R8 unselected port ignored", ng - base, 0);
        chk(cur_port == 0, "R8 no switch mid-frame", cur_port, 0);
        send_mark(0, 8'h01);
        send_pix(0, 8'h66);
        send_mark(0, 8'h02);
        idle(4);
        chk(ng - base == 1 && got[base] == 8'h66, "R8 old port still live", got[base], 8'h66);
        send_mark(0, 8'h03);
        idle(4);
        chk(cur_port == 1, "R8 switch at frame start", cur_port, 1);
        base = ng;
        send_mark(1, 8'h01);
        send_pix(1, 8'h99);
        send_mark(1, 8'h02);
        idle(4);
        chk(ng - base == 1 && got[base] == 8'h99, "R8 new port live", got[base], 8'h99);
        cfg_port_sel = 1'b0;
        send_mark(1, 8'h03);
        idle(4);
        chk(cur_port == 0, "R8 switch back", cur_port, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule